// File: doc/BRIEF.md
# Infrared Receive Input Conditioner with Carrier Demodulator

This block sits at the front of an infrared receiver. It takes the raw, asynchronous line from the optical detector and brings it into the receive clock domain through a two-flop synchronizer. A persistence filter then removes any level that does not last a programmable number of enabled cycles. The filtered level drives rising-edge and falling-edge detectors, which produce single-cycle pulses.

An optional demodulator turns a carrier-modulated signal into its baseband envelope. A rising edge of the filtered level starts a hunt. Three further edges must then follow, each arriving before a programmable gap timer expires. Only then does the envelope output go high. While the envelope is high, each carrier rising edge restarts the gap timer, and the envelope falls once the timer expires with no new rising edge. When demodulation is turned off, the envelope output mirrors the filtered level. Pulse-width measurement and any storage of results belong to the logic downstream of this block.

Top module: `ir_rx_frontend`

## Requirements
- R1: A change on `rx_raw` passes through two synchronizer flops before it reaches the filter. With threshold T (T of at least 1) and `ce` held high, a change driven before clock edge 1 appears on `filt_level` right after clock edge T+2 and not before.
- R2: A new input level is accepted only after it has been seen for `glitch_len` consecutive enabled cycles. A high pulse of W cycles with W below `glitch_len` leaves `filt_level` unchanged. A `glitch_len` of 0 acts as 1.
- R3: In a clock cycle where `ce` is low, the filter neither accepts a level nor advances its count, so `filt_level` holds.
- R4: `rise_pulse` is high for exactly one clock after each 0-to-1 change of `filt_level`, and `fall_pulse` likewise after each 1-to-0 change. The two pulses are never high together.
- R5: With `demod_en` = 1, `env_out` rises only after a rising edge of the filtered level is followed by three more edges (falling, rising, falling). A rise-fall-rise sequence alone never asserts it.
- R6: The gap timer counts enabled cycles since the last accepted edge and expires on reaching `gap_len`. While hunting, expiry abandons the hunt. While the envelope is high, only rising edges restart the timer, and expiry drops `env_out`.
- R7: With `demod_en` = 0, `env_out` equals `filt_level` in every cycle.
- R8: A synchronous active-high `rst` clears `filt_level`, both edge pulses and `env_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the filter and the gap timer |
| rx_raw | input | 1 | Asynchronous raw infrared input |
| glitch_len | input | THR_W | Minimum accepted level length, in enabled cycles |
| demod_en | input | 1 | 1 selects the carrier envelope, 0 passes the filtered level |
| gap_len | input | GAP_W | Carrier gap timeout, in enabled cycles |
| filt_level | output | 1 | Synchronized and filtered level |
| rise_pulse | output | 1 | Single-cycle pulse on a filtered rising edge |
| fall_pulse | output | 1 | Single-cycle pulse on a filtered falling edge |
| env_out | output | 1 | Demodulated envelope, or the filtered level when demodulation is off |

## Verification
The filter is driven with single high pulses whose widths straddle each threshold: one cycle short of it, exactly at it, and well above it, with a zero threshold as an extra case. These pulses separate an off-by-one in the persistence count from a correct accept. An exact-latency probe pins the depth of the synchronizer and filter to the clock. The demodulator receives a long carrier burst, a two-period burst, a burst cut off after rise-fall-rise, and a slow square wave whose edges are spaced wider than the gap. Together these distinguish the edge count needed for lock, hold of the envelope through the carrier's low phases, and gap-timer expiry in both the hunt and the locked state.

// File: rtl/ir_fe_pkg.sv
package ir_fe_pkg;

    localparam int DEF_THR_W       = 8;
    localparam int DEF_GAP_W       = 12;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int EDGES_TO_LOCK   = 3;   // edges after the aligning rise

    typedef enum logic [1:0] {
        DM_IDLE = 2'd0,
        DM_HUNT = 2'd1,
        DM_LOCK = 2'd2
    } dm_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // a zero threshold behaves like a threshold of one
    function automatic logic [DEF_THR_W:0] eff_thr(input logic [DEF_THR_W-1:0] thr);
        return (thr == '0) ? {{DEF_THR_W{1'b0}}, 1'b1} : {1'b0, thr};
    endfunction

endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
    parameter int STAGES = ir_fe_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
    parameter int THR_W = ir_fe_pkg::DEF_THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             din,
    input  logic [THR_W-1:0] thr,
    output logic             level
);
    logic [THR_W-1:0] run_cnt;
    logic [THR_W:0]   run_next;
    logic [THR_W:0]   need;

    always_comb begin
        need     = (thr == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr};
        run_next = {1'b0, run_cnt} + 1'b1;
    end

    // stage one: persistence counter; stage two: the accepted level register
    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= 1'b0;
            run_cnt <= '0;
        end else if (ce) begin
            if (din == level) begin
                run_cnt <= '0;
            end else if (run_next >= need) begin
                level   <= din;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_next[THR_W-1:0];
            end
        end
    end

    // R2: a new level is only ever the level seen at the input
    p_accept_from_input_r2: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> (level == $past(din)));

    // R3: with ce low the level register holds
    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(ce) |-> $stable(level));
endmodule

// File: rtl/ir_edge_det.sv
module ir_edge_det
    import ir_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    output edge_t edges
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    always_comb begin
        edges.rise = level & ~prev;
        edges.fall = ~level & prev;
    end

    // R4: single-cycle pulses, never both at once
    p_rise_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise);
    p_fall_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> !edges.fall);
    p_edges_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(edges.rise && edges.fall));
endmodule

// File: rtl/ir_demod.sv
module ir_demod
    import ir_fe_pkg::*;
#(
    parameter int GAP_W = DEF_GAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             enable,
    input  edge_t            edges,
    input  logic [GAP_W-1:0] gap,
    output logic             locked
);
    localparam int CNT_W = $clog2(EDGES_TO_LOCK + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES_TO_LOCK - 1);

    dm_state_t        st;
    logic [CNT_W-1:0] edge_cnt;
    logic [GAP_W-1:0] tmr;
    logic             expire;
    logic             any_edge;

    always_comb begin
        any_edge = edges.rise | edges.fall;
        expire   = ({1'b0, tmr} + 1'b1) >= {1'b0, gap};
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st       <= DM_IDLE;
            edge_cnt <= '0;
            tmr      <= '0;
        end else begin
            unique case (st)
                DM_IDLE: begin
                    if (edges.rise) begin
                        st       <= DM_HUNT;
                        edge_cnt <= '0;
                        tmr      <= '0;
                    end
                end
                DM_HUNT: begin
                    if (any_edge) begin
                        tmr <= '0;
                        if (edge_cnt == LAST_EDGE) begin
                            st       <= DM_LOCK;
                            edge_cnt <= '0;
                        end else begin
                            edge_cnt <= edge_cnt + 1'b1;
                        end
                    end else if (ce) begin
                        if (expire) st  <= DM_IDLE;
                        else        tmr <= tmr + 1'b1;
                    end
                end
                DM_LOCK: begin
                    if (edges.rise) begin
                        tmr <= '0;
                    end else if (ce) begin
                        if (expire) st  <= DM_IDLE;
                        else        tmr <= tmr + 1'b1;
                    end
                end
                default: st <= DM_IDLE;
            endcase
        end
    end

    assign locked = (st == DM_LOCK);

    // R5: lock is entered only on the closing (falling) edge of the sequence
    p_lock_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && !$past(locked)) |-> $past(edges.fall));

    // R6: while locked, a cycle with no rising edge and ce low keeps the lock
    p_lock_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && enable && !edges.rise && !ce) |=> locked);
endmodule

// File: rtl/ir_rx_frontend.sv
module ir_rx_frontend
    import ir_fe_pkg::*;
#(
    parameter int THR_W       = DEF_THR_W,
    parameter int GAP_W       = DEF_GAP_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             rx_raw,
    input  logic [THR_W-1:0] glitch_len,
    input  logic             demod_en,
    input  logic [GAP_W-1:0] gap_len,
    output logic             filt_level,
    output logic             rise_pulse,
    output logic             fall_pulse,
    output logic             env_out
);
    logic  rx_sync;
    logic  lvl;
    edge_t edges;
    logic  locked;

    ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_raw),
        .dout (rx_sync)
    );

    ir_glitch_filter #(.THR_W(THR_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .din   (rx_sync),
        .thr   (glitch_len),
        .level (lvl)
    );

    ir_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lvl),
        .edges (edges)
    );

    ir_demod #(.GAP_W(GAP_W)) u_demod (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .enable (demod_en),
        .edges  (edges),
        .gap    (gap_len),
        .locked (locked)
    );

    always_comb begin
        filt_level = lvl;
        rise_pulse = edges.rise;
        fall_pulse = edges.fall;
        env_out    = demod_en ? locked : lvl;
    end

    // R8: the cycle after a reset cycle shows a cleared filter and envelope
    p_reset_clears_r8: assert property (@(posedge clk)
        $past(rst) |-> (!filt_level && !env_out));
endmodule

// File: tb/tb_ir_rx_frontend.sv
module tb_ir_rx_frontend;
    logic        clk = 1'b0;
    logic        rst;
    logic        ce;
    logic        rx_raw;
    logic [7:0]  glitch_len;
    logic        demod_en;
    logic [11:0] gap_len;
    logic        filt_level, rise_pulse, fall_pulse, env_out;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0, fall_cnt = 0, dbl_cnt = 0, env_mis = 0;
    bit env_seen = 0;
    bit prev_rise = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    ir_rx_frontend dut (
        .clk(clk), .rst(rst), .ce(ce), .rx_raw(rx_raw),
        .glitch_len(glitch_len), .demod_en(demod_en), .gap_len(gap_len),
        .filt_level(filt_level), .rise_pulse(rise_pulse),
        .fall_pulse(fall_pulse), .env_out(env_out)
    );

    // {threshold, high pulse width, expected rising edges}
    localparam logic [16:0] VEC [0:7] = '{
        {8'd1, 8'd1, 1'b1},
        {8'd2, 8'd1, 1'b0},
        {8'd2, 8'd2, 1'b1},
        {8'd4, 8'd3, 1'b0},
        {8'd4, 8'd4, 1'b1},
        {8'd0, 8'd1, 1'b1},
        {8'd6, 8'd5, 1'b0},
        {8'd6, 8'd9, 1'b1}
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst) begin
            if (rise_pulse) rise_cnt++;
            if (fall_pulse) fall_cnt++;
            if (rise_pulse && prev_rise) dbl_cnt++;
            if (rise_pulse && fall_pulse) dbl_cnt++;
            if (env_out) env_seen = 1;
        end
        prev_rise = rise_pulse;
    end

    always @(negedge clk)
        if (!rst && !demod_en && env_out != filt_level) env_mis++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic carrier(input int periods);
        for (int p = 0; p < periods; p++) begin
            rx_raw = 1'b1; cyc(4);
            rx_raw = 1'b0; cyc(4);
        end
    endtask

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rc0, fc0;
        rst = 1'b1; ce = 1'b1; rx_raw = 1'b1; glitch_len = 8'd1;
        demod_en = 1'b0; gap_len = 12'd12;
        cyc(6);
        // R8: reset holds everything low even with the input high
        chk(!filt_level && !env_out && !rise_pulse && !fall_pulse,
            "R8 reset outputs", {filt_level, env_out, rise_pulse, fall_pulse}, 0);
        rx_raw = 1'b0;
        cyc(2);
        rst = 1'b0;
        cyc(10);

        // R2/R4 vector table: pulse width against threshold
        for (int i = 0; i < 8; i++) begin
            glitch_len = VEC[i][16:9];
            rx_raw = 1'b0; cyc(20);
            rc0 = rise_cnt; fc0 = fall_cnt;
            rx_raw = 1'b1; cyc(int'(VEC[i][8:1]));
            rx_raw = 1'b0; cyc(20);
            chk(rise_cnt - rc0 == int'(VEC[i][0]), "R2 accept vs threshold",
                rise_cnt - rc0, int'(VEC[i][0]));
            chk(fall_cnt - fc0 == int'(VEC[i][0]), "R4 fall pulse count",
                fall_cnt - fc0, int'(VEC[i][0]));
            chk(filt_level == 1'b0, "R2 level settles low", filt_level, 0);
        end

        // R1: exact latency with threshold 3 -> visible after edge 5
        glitch_len = 8'd3;
        rx_raw = 1'b1;
        cyc(4);
        chk(filt_level == 1'b0, "R1 not before edge T+2", filt_level, 0);
        cyc(1);
        chk(filt_level == 1'b1, "R1 at edge T+2", filt_level, 1);
        chk(rise_pulse == 1'b1, "R4 rise pulse present", rise_pulse, 1);
        cyc(1);
        chk(rise_pulse == 1'b0, "R4 rise pulse one cycle", rise_pulse, 0);

        // R3: ce low freezes the filter
        ce = 1'b0;
        rx_raw = 1'b0;
        cyc(15);
        chk(filt_level == 1'b1, "R3 hold with ce low", filt_level, 1);
        ce = 1'b1;
        cyc(8);
        chk(filt_level == 1'b0, "R3 resumes with ce high", filt_level, 0);

        // R7: demod off -> envelope mirrors level (monitor plus spot check)
        glitch_len = 8'd1;
        rx_raw = 1'b1; cyc(6);
        chk(env_out == 1'b1, "R7 env follows level", env_out, 1);
        rx_raw = 1'b0; cyc(6);

        // demodulator tests: threshold 2, gap 12
        glitch_len = 8'd2; gap_len = 12'd12; demod_en = 1'b1;
        cyc(30);

        // R5/R6: long carrier, envelope held through low phases
        env_seen = 0;
        carrier(5);
        rx_raw = 1'b1; cyc(2);
        chk(env_out == 1'b1, "R5 env high during carrier", env_out, 1);
        rx_raw = 1'b1; cyc(2);
        rx_raw = 1'b0; cyc(2);
        chk(env_out == 1'b1, "R6 env held in carrier low", env_out, 1);
        cyc(2);
        carrier(4);
        cyc(30);
        chk(env_out == 1'b0, "R6 env drops after gap", env_out, 0);

        // R5: two periods give rise,fall,rise,fall -> lock
        env_seen = 0;
        carrier(2);
        cyc(30);
        chk(env_seen == 1'b1, "R5 lock after three more edges", env_seen, 1);

        // R5: rise,fall,rise only -> never locks
        env_seen = 0;
        rx_raw = 1'b1; cyc(4);
        rx_raw = 1'b0; cyc(4);
        rx_raw = 1'b1; cyc(40);
        rx_raw = 1'b0; cyc(30);
        chk(env_seen == 1'b0, "R5 no lock on two extra edges", env_seen, 0);

        // R6: edges spaced beyond the gap never lock
        env_seen = 0;
        for (int p = 0; p < 4; p++) begin
            rx_raw = 1'b1; cyc(20);
            rx_raw = 1'b0; cyc(20);
        end
        cyc(10);
        chk(env_seen == 1'b0, "R6 hunt abandoned on gap", env_seen, 0);

        demod_en = 1'b0;
        cyc(5);
        chk(env_mis == 0, "R7 env equals level while demod off", env_mis, 0);
        chk(dbl_cnt == 0, "R4 pulses single and exclusive", dbl_cnt, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule